// File: doc/BRIEF.md
# Shared-Pin Serial Register Control Port

This block is a slave configuration port. Three pins carry either of two serial buses. The first bus is a write-only SPI bus, which has a chip select, a clock and a data input. The second bus is a two-wire bus that resembles I2C. On that bus the chip-select pin is a static address bit, the clock pin is SCL and the data pin is SDA. The port decodes the device address and loads a bank of eleven 8-bit configuration registers at addresses 0x00 to 0x0A. On the two-wire bus it can also read a register back. The whole bank appears as a flat parallel output, and the analog and datapath logic that the registers control reads it from there.

All three pins are sampled by the internal system clock through synchronisers, and the port reacts to edge events in that clock domain. The chip-select pin starts high, so the port comes out of reset as a two-wire slave. The first falling edge seen on that pin switches the port to SPI permanently. In SPI mode the two-wire sequencer is held idle and never drives SDA. SDA is open drain, so the port drives it only through a pull-low enable.

The two-wire bus differs from I2C in one way: the slave acknowledges the address byte and the register-address byte, but it sends no acknowledge after a data byte, in either direction.

Top module: `rcp_port`

## Requirements
- R1: After reset the registers hold 0x0C at index 2, 0x06 at index 3, 0x20 at index 6, 0x08 at index 7, 0x2A at index 8, and 0x00 at every other index. The pull-low enable is inactive after reset.
- R2: A falling edge on `csb_ad0` switches the port to SPI mode, and it stays in SPI mode until reset. From then on two-wire traffic writes nothing and gets no acknowledge.
- R3: An SPI write is 24 bits, sampled on rising edges of `bus_clk` while `csb_ad0` is low, MSB first. The bits are a header byte of 0x20 (device ID 0010000 followed by R/W = 0), then a register address, then a data byte. The register is written once the 24th bit is in.
- R4: An SPI frame is ignored until the next falling edge of chip select if its header is not 0x20, which includes any header with R/W = 1, or if chip select rises before 24 bits have arrived.
- R5: On the two-wire bus, a start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. The slave address is 001000 followed by the level of `csb_ad0`, and then an R/W bit. A matching address byte is acknowledged by pulling SDA low through the ninth clock.
- R6: In a two-wire write, the byte after the address is the register pointer and is acknowledged. The next byte is written to that register and is not acknowledged: SDA stays released during a ninth clock.
- R7: In a two-wire read, the address byte has R/W = 1 and comes after an earlier write-direction transfer that set the pointer. The slave then shifts out the pointed register MSB first, changing bits after SCL falls. It pulls SDA low for 0 bits and gives no acknowledge afterwards.
- R8: A two-wire address byte that does not match gets no acknowledge, and the rest of the transfer is ignored until the next start.
- R9: Writes to register addresses above 0x0A have no effect on any register. Two-wire reads from such addresses return 0x00.
- R10: Register n appears on `reg_image[8n+7:8n]`. `ctrl_port_mode` follows bit 7 of register 0x00. The registers change only through accepted writes.
- R11: The pull-low enable rises only just after a falling edge of SCL, is inactive in SPI mode, and is released by a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all bus pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| csb_ad0 | input | 1 | SPI chip select (active low) or two-wire address bit |
| bus_clk | input | 1 | SPI clock or two-wire SCL |
| bus_data_in | input | 1 | SPI data in or two-wire SDA line level |
| bus_data_pull_low | output | 1 | Drives SDA low when 1 (open-drain enable) |
| ctrl_port_mode | output | 1 | Bit 7 of register 0x00 |
| reg_image | output | 88 | All eleven registers, register n in bits 8n+7:8n |

## Verification
The hardest case to reach is the two-wire read turnaround. A write-direction address byte and a pointer byte must be sent, then a repeated start, then a read-direction address byte. The slave must take over SDA on the exact SCL falling edge that ends the acknowledge. The bench models the wired-AND SDA line from the master level and the pull-low enable. It runs complete write-then-read transfers for every register, and separately for out-of-range pointers. The one-way switch into SPI mode can be seen only by its effects. After reset the bench lowers chip select, then shows that two-wire transfers are unacknowledged and write nothing, while SPI frames still land.

// File: rtl/rcp_pkg.sv
package rcp_pkg;

  localparam int REG_W    = 8;
  localparam int NUM_REGS = 11;
  localparam int IMG_W    = NUM_REGS * REG_W;
  localparam logic [6:0] DEV_ID = 7'b0010000;
  localparam int SPI_FRAME_BITS = 24;

  typedef enum logic [2:0] {
    TW_IDLE,
    TW_ADDR,
    TW_ADDR_ACK,
    TW_REG,
    TW_REG_ACK,
    TW_WDATA,
    TW_RDATA,
    TW_HOLD
  } tw_state_e;

  // reset value of each register
  function automatic logic [REG_W-1:0] reg_default(input int idx);
    case (idx)
      2:       return 8'h0C;
      3:       return 8'h06;
      6:       return 8'h20;
      7:       return 8'h08;
      8:       return 8'h2A;
      default: return 8'h00;
    endcase
  endfunction

  // two-wire address byte: six fixed id bits, pin level, then R/W
  function automatic logic tw_addr_match(input logic [7:0] b, input logic ad0);
    return b[7:1] == {DEV_ID[6:1], ad0};
  endfunction

  // SPI header: full id with R/W = 0 (write only)
  function automatic logic spi_hdr_ok(input logic [7:0] b);
    return b == {DEV_ID, 1'b0};
  endfunction

  function automatic logic reg_in_range(input logic [7:0] a);
    return a < 8'(NUM_REGS);
  endfunction

endpackage

// File: rtl/rcp_pin_sync.sv
module rcp_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], pin};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= pin;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~prev;
  assign fall  = ~chain[STAGES-1] & prev;

endmodule

// File: rtl/rcp_spi_rx.sv
module rcp_spi_rx
  import rcp_pkg::*;
#(
  parameter int FRAME_BITS = SPI_FRAME_BITS
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_fall,
  input  logic       cs_rise,
  input  logic       sck_rise,
  input  logic       din,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data
);

  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic [FRAME_BITS-2:0] shreg;
  logic [CNT_W-1:0]      bitcnt;
  logic                  active;
  logic                  hdr_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bitcnt  <= '0;
      active  <= 1'b0;
      hdr_bad <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (cs_fall) begin
        active  <= 1'b1;
        bitcnt  <= '0;
        hdr_bad <= 1'b0;
      end else if (cs_rise) begin
        active <= 1'b0;
      end else if (active && sck_rise && bitcnt < CNT_W'(FRAME_BITS)) begin
        shreg  <= {shreg[FRAME_BITS-3:0], din};
        bitcnt <= bitcnt + 1'b1;
        if (bitcnt == CNT_W'(7))
          hdr_bad <= !spi_hdr_ok({shreg[6:0], din});
        if (bitcnt == CNT_W'(FRAME_BITS - 1) && !hdr_bad) begin
          wr_en   <= 1'b1;
          wr_addr <= shreg[14:7];
          wr_data <= {shreg[6:0], din};
        end
      end
    end
  end

endmodule

// File: rtl/rcp_tw_slave.sv
module rcp_tw_slave
  import rcp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       ad0,
  input  logic       scl_level,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_level,
  input  logic       sda_rise,
  input  logic       sda_fall,
  input  logic [7:0] rd_data,
  output logic [7:0] reg_ptr,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic       pull_low,
  output logic       stop_ev
);

  tw_state_e  st;
  logic [7:0] sh;
  logic [3:0] cnt;
  logic       rw;
  logic       start_ev;

  assign start_ev = enable & scl_level & sda_fall;
  assign stop_ev  = enable & scl_level & sda_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= TW_IDLE;
      sh       <= '0;
      cnt      <= '0;
      rw       <= 1'b0;
      reg_ptr  <= '0;
      wr_en    <= 1'b0;
      wr_data  <= '0;
      pull_low <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (!enable) begin
        st       <= TW_IDLE;
        pull_low <= 1'b0;
      end else if (start_ev) begin
        st       <= TW_ADDR;
        cnt      <= '0;
        pull_low <= 1'b0;
      end else if (stop_ev) begin
        st       <= TW_IDLE;
        pull_low <= 1'b0;
      end else begin
        case (st)
          TW_ADDR, TW_REG, TW_WDATA: begin
            if (scl_rise && cnt < 4'd8) begin
              sh  <= {sh[6:0], sda_level};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (st == TW_ADDR) begin
                if (tw_addr_match(sh, ad0)) begin
                  rw       <= sh[0];
                  st       <= TW_ADDR_ACK;
                  pull_low <= 1'b1;
                end else begin
                  st <= TW_HOLD;
                end
              end else if (st == TW_REG) begin
                reg_ptr  <= sh;
                st       <= TW_REG_ACK;
                pull_low <= 1'b1;
              end else begin
                wr_en   <= 1'b1;
                wr_data <= sh;
                st      <= TW_HOLD;
              end
            end
          end
          TW_ADDR_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                st       <= TW_RDATA;
                sh       <= rd_data;
                pull_low <= ~rd_data[7];
              end else begin
                st       <= TW_REG;
                pull_low <= 1'b0;
              end
            end
          end
          TW_REG_ACK: begin
            if (scl_fall) begin
              st       <= TW_WDATA;
              cnt      <= '0;
              pull_low <= 1'b0;
            end
          end
          TW_RDATA: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                pull_low <= 1'b0;
                st       <= TW_HOLD;
              end else begin
                sh       <= {sh[6:0], 1'b0};
                pull_low <= ~sh[6];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/rcp_reg_bank.sv
module rcp_reg_bank
  import rcp_pkg::*;
#(
  parameter int N = NUM_REGS,
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [7:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [7:0]   rd_addr,
  output logic [W-1:0] rd_data,
  output logic [N*W-1:0] image
);

  logic [W-1:0] mem [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) mem[i] <= W'(reg_default(i));
    end else if (wr_en) begin
      for (int i = 0; i < N; i++)
        if (wr_addr == 8'(i)) mem[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N; i++)
      if (rd_addr == 8'(i)) rd_data = mem[i];
  end

  generate
    for (genvar g = 0; g < N; g++) begin : g_img
      assign image[g*W +: W] = mem[g];
    end
  endgenerate

endmodule

// File: rtl/rcp_port.sv
module rcp_port
  import rcp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csb_ad0,
  input  logic             bus_clk,
  input  logic             bus_data_in,
  output logic             bus_data_pull_low,
  output logic             ctrl_port_mode,
  output logic [IMG_W-1:0] reg_image
);

  logic sel_level, sel_rise, sel_fall;
  logic clk_level, clk_rise, clk_fall;
  logic dat_level, dat_rise, dat_fall;

  rcp_pin_sync #(.STAGES(2)) u_sync_sel (
    .clk(clk), .rst_n(rst_n), .pin(csb_ad0),
    .level(sel_level), .rise(sel_rise), .fall(sel_fall)
  );
  rcp_pin_sync #(.STAGES(2)) u_sync_clk (
    .clk(clk), .rst_n(rst_n), .pin(bus_clk),
    .level(clk_level), .rise(clk_rise), .fall(clk_fall)
  );
  rcp_pin_sync #(.STAGES(2)) u_sync_dat (
    .clk(clk), .rst_n(rst_n), .pin(bus_data_in),
    .level(dat_level), .rise(dat_rise), .fall(dat_fall)
  );

  // sticky bus-mode latch
  logic spi_mode;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) spi_mode <= 1'b0;
    else        spi_mode <= spi_mode | sel_fall;
  end

  logic       spi_wr_en;
  logic [7:0] spi_wr_addr, spi_wr_data;

  rcp_spi_rx u_spi (
    .clk(clk), .rst_n(rst_n),
    .cs_fall(sel_fall), .cs_rise(sel_rise),
    .sck_rise(clk_rise), .din(dat_level),
    .wr_en(spi_wr_en), .wr_addr(spi_wr_addr), .wr_data(spi_wr_data)
  );

  logic       tw_wr_en;
  logic [7:0] tw_ptr, tw_wr_data, rd_data;
  logic       tw_stop;
  logic       sda_pull_low;
  logic       tw_scl_fall;

  assign tw_scl_fall = clk_fall;

  rcp_tw_slave u_tw (
    .clk(clk), .rst_n(rst_n), .enable(!spi_mode), .ad0(sel_level),
    .scl_level(clk_level), .scl_rise(clk_rise), .scl_fall(clk_fall),
    .sda_level(dat_level), .sda_rise(dat_rise), .sda_fall(dat_fall),
    .rd_data(rd_data), .reg_ptr(tw_ptr), .wr_en(tw_wr_en),
    .wr_data(tw_wr_data), .pull_low(sda_pull_low), .stop_ev(tw_stop)
  );

  // the two sources are exclusive by mode
  logic       wr_en;
  logic [7:0] wr_addr, wr_data;
  assign wr_en   = spi_wr_en | tw_wr_en;
  assign wr_addr = spi_wr_en ? spi_wr_addr : tw_ptr;
  assign wr_data = spi_wr_en ? spi_wr_data : tw_wr_data;

  logic [IMG_W-1:0] regs_flat;

  rcp_reg_bank #(.N(NUM_REGS), .W(REG_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(tw_ptr), .rd_data(rd_data), .image(regs_flat)
  );

  assign reg_image         = regs_flat;
  assign ctrl_port_mode    = regs_flat[7];
  assign bus_data_pull_low = sda_pull_low;

endmodule

// File: rtl/rcp_port_chk.sv
module rcp_port_chk
  import rcp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             spi_mode,
  input logic             sda_pull_low,
  input logic             wr_en,
  input logic [7:0]       wr_addr,
  input logic [IMG_W-1:0] regs_flat,
  input logic             tw_scl_fall,
  input logic             tw_stop
);

  // R2
  spi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_mode |=> spi_mode);

  // R11
  no_pull_in_spi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_mode |=> !sda_pull_low);

  // R11
  pull_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_low) |-> $past(tw_scl_fall));

  // R11
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tw_stop |=> !sda_pull_low);

  // R9
  range_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= 8'(NUM_REGS)) |=> $stable(regs_flat));

  // R10
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_flat));

endmodule

bind rcp_port rcp_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .spi_mode(spi_mode), .sda_pull_low(sda_pull_low),
  .wr_en(wr_en), .wr_addr(wr_addr), .regs_flat(regs_flat),
  .tw_scl_fall(tw_scl_fall), .tw_stop(tw_stop)
);

// File: tb/rcp_port_tb.sv
module rcp_port_tb;

  localparam int NR = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b1;
  logic bclk = 1'b1;
  logic bdat = 1'b1;
  logic pull;
  logic mode_out;
  logic [NR*8-1:0] image;
  logic line;

  int total = 0;
  int bad = 0;
  logic [7:0] expv [NR];

  always #10 clk = ~clk;

  assign line = bdat & ~pull;

  rcp_port u_dut (
    .clk(clk), .rst_n(rst_n), .csb_ad0(sel), .bus_clk(bclk),
    .bus_data_in(line), .bus_data_pull_low(pull),
    .ctrl_port_mode(mode_out), .reg_image(image)
  );

  function automatic logic [7:0] pat(input int i, input int k);
    return 8'((i * 29 + k * 83 + 17) & 255);
  endfunction

  function automatic logic [7:0] dflt(input int i);
    case (i)
      2: return 8'h0C;
      3: return 8'h06;
      6: return 8'h20;
      7: return 8'h08;
      8: return 8'h2A;
      default: return 8'h00;
    endcase
  endfunction

  task automatic wt(input int units);
    repeat (units * 4) @(negedge clk);
  endtask

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_image(input string tag);
    for (int i = 0; i < NR; i++) chk8(tag, image[8*i +: 8], expv[i]);
  endtask

  task automatic do_reset(input logic ad0, input logic clk_idle);
    rst_n = 1'b0;
    sel = ad0;
    bclk = clk_idle;
    bdat = 1'b1;
    wt(2);
    rst_n = 1'b1;
    wt(2);
    for (int i = 0; i < NR; i++) expv[i] = dflt(i);
  endtask

  task automatic tw_start();
    bdat = 1'b1; wt(2);
    bclk = 1'b1; wt(2);
    bdat = 1'b0; wt(2);
    bclk = 1'b0; wt(1);
  endtask

  task automatic tw_stop();
    bdat = 1'b0; wt(2);
    bclk = 1'b1; wt(2);
    bdat = 1'b1; wt(2);
  endtask

  task automatic tw_send(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      bdat = b[i]; wt(2);
      bclk = 1'b1; wt(2);
      bclk = 1'b0; wt(1);
    end
    bdat = 1'b1; wt(2);
    bclk = 1'b1; wt(1);
    acked = ~line;
    wt(1);
    bclk = 1'b0; wt(1);
  endtask

  task automatic tw_recv(output logic [7:0] b);
    bdat = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(2);
      bclk = 1'b1; wt(1);
      b[i] = line;
      wt(1);
      bclk = 1'b0; wt(1);
    end
  endtask

  task automatic tw_write(input logic [6:0] dev, input logic [7:0] ra, input logic [7:0] d,
                          output logic a0, output logic a1, output logic a2);
    tw_start();
    tw_send({dev, 1'b0}, a0);
    tw_send(ra, a1);
    tw_send(d, a2);
    tw_stop();
  endtask

  task automatic tw_read(input logic [6:0] dev, input logic [7:0] ra, output logic [7:0] d,
                         output logic a0, output logic a1, output logic a2);
    tw_start();
    tw_send({dev, 1'b0}, a0);
    tw_send(ra, a1);
    tw_start();
    tw_send({dev, 1'b1}, a2);
    tw_recv(d);
    tw_stop();
  endtask

  task automatic spi_frame(input logic [7:0] h, input logic [7:0] ra, input logic [7:0] d,
                           input int nbits);
    logic [23:0] w;
    w = {h, ra, d};
    bclk = 1'b0;
    sel = 1'b0; wt(2);
    for (int i = 0; i < nbits; i++) begin
      bdat = w[23-i]; wt(2);
      bclk = 1'b1; wt(2);
      bclk = 1'b0;
    end
    wt(2);
    sel = 1'b1; wt(4);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic a0, a1, a2;
    logic [7:0] rd;

    // ---------- two-wire, AD0 = 1 ----------
    do_reset(1'b1, 1'b1);
    chk_image("R1 reset defaults");
    chk8("R1 pull released after reset", {7'd0, pull}, 8'd0);
    chk8("R10 mode bit after reset", {7'd0, mode_out}, 8'd0);

    // R5 R6 sweep of writes over every register
    for (int i = 0; i < NR; i++) begin
      tw_write(7'h11, 8'(i), pat(i, 1), a0, a1, a2);
      expv[i] = pat(i, 1);
      chk8("R5 address acked", {7'd0, a0}, 8'd1);
      chk8("R6 pointer acked", {7'd0, a1}, 8'd1);
      chk8("R6 data not acked", {7'd0, a2}, 8'd0);
    end
    chk_image("R6 R10 image after two-wire writes");
    chk8("R10 mode bit follows reg0", {7'd0, mode_out}, {7'd0, expv[0][7]});

    // R7 read back every register
    for (int i = 0; i < NR; i++) begin
      tw_read(7'h11, 8'(i), rd, a0, a1, a2);
      chk8("R7 read ack", {5'd0, a0, a1, a2}, 8'h07);
      chk8("R7 read data", rd, expv[i]);
    end

    tw_write(7'h11, 8'h00, 8'h80, a0, a1, a2);
    expv[0] = 8'h80;
    chk8("R10 mode bit set", {7'd0, mode_out}, 8'd1);

    // R9 out-of-range pointer
    tw_write(7'h11, 8'h0B, 8'h5A, a0, a1, a2);
    tw_write(7'h11, 8'hFF, 8'hA5, a0, a1, a2);
    chk_image("R9 high writes ignored");
    tw_read(7'h11, 8'h0B, rd, a0, a1, a2);
    chk8("R9 read 0x0B", rd, 8'h00);
    tw_read(7'h11, 8'hC3, rd, a0, a1, a2);
    chk8("R9 read 0xC3", rd, 8'h00);

    // R8 wrong device address
    tw_write(7'h10, 8'h04, 8'h3C, a0, a1, a2);
    chk8("R8 no ack on mismatch", {6'd0, a0, a1}, 8'd0);
    tw_write(7'h19, 8'h05, 8'hC3, a0, a1, a2);
    chk8("R8 no ack other id", {7'd0, a0}, 8'd0);
    chk_image("R8 mismatch writes nothing");

    // ---------- two-wire, AD0 = 0 ----------
    do_reset(1'b0, 1'b1);
    chk_image("R1 defaults again");
    tw_write(7'h10, 8'h05, 8'h99, a0, a1, a2);
    expv[5] = 8'h99;
    chk8("R5 AD0=0 address acked", {7'd0, a0}, 8'd1);
    tw_write(7'h11, 8'h05, 8'h11, a0, a1, a2);
    chk8("R8 AD0=0 other address", {7'd0, a0}, 8'd0);
    chk_image("R5 R8 image with AD0=0");

    // ---------- SPI ----------
    do_reset(1'b1, 1'b0);
    for (int i = 0; i < NR; i++) begin
      spi_frame(8'h20, 8'(i), pat(i, 2), 24);
      expv[i] = pat(i, 2);
    end
    chk_image("R2 R3 SPI writes");
    chk8("R10 mode bit via SPI", {7'd0, mode_out}, {7'd0, expv[0][7]});

    spi_frame(8'h24, 8'h01, 8'h00, 24);
    chk_image("R4 bad header ignored");
    spi_frame(8'h21, 8'h02, 8'h00, 24);
    chk_image("R4 read header ignored");
    spi_frame(8'h20, 8'h03, 8'h00, 16);
    chk_image("R4 short frame ignored");
    spi_frame(8'h20, 8'h0B, 8'hEE, 24);
    chk_image("R9 SPI high address ignored");
    spi_frame(8'h20, 8'h03, 8'h5D, 24);
    expv[3] = 8'h5D;
    chk_image("R3 SPI write after ignored frames");

    // R2 two-wire traffic after the mode switch
    bclk = 1'b1; bdat = 1'b1; wt(2);
    tw_write(7'h11, 8'h04, 8'h77, a0, a1, a2);
    chk8("R2 no ack in SPI mode", {6'd0, a0, a1}, 8'd0);
    chk8("R11 pull idle in SPI mode", {7'd0, pull}, 8'd0);
    chk_image("R2 two-wire ignored in SPI mode");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule